// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipeline from a small bank of registers that software fills through a single-cycle write port. It runs a pixel counter and a line counter, and from them derives a display-enable window, horizontal and vertical sync, a composite sync intended for the green channel, and a one-cycle prefetch pulse that fires at a programmable pixel position on every line. Every extent and position register holds its target count minus one, so a line of N pixels is programmed as N-1.

Sync outputs can be individually inverted or switched off, and a global sync-off serves as the power-down state. A separate display-blank control removes the display-enable window while the counters keep running. The block also holds a pan offset (x, y) for the refresh fetch. A new offset is staged on write and only goes live at the wrap from the last pixel of the last line to the first, so a pan never tears a frame.

Software clears the enable bit before it reprograms the timing. While enable is low, both counters sit at zero and the staged pan offset passes straight through.

Top module: `disp_tgen`

## Requirements
- R1: During and after reset all counters are zero, and display enable, both syncs, composite sync, prefetch and both pan outputs are low.
- R2: While enabled, the pixel counter steps by one per clock from 0 and returns to 0 after the cycle in which it is at or above the programmed horizontal total. The line counter steps by one on each such pixel wrap and returns to 0 after a wrap in which it is at or above the vertical total.
- R3: While control bit 0 (enable) is 0, both counters are held at 0 and the syncs, before any inversion, are inactive.
- R4: Display enable is high exactly when enable and control bit 1 (refresh) are both set, blank is clear, the pixel count is at most the horizontal active register and the line count is at most the vertical active register.
- R5: Raw hsync is active for pixel counts strictly above the hsync-begin register and at most the hsync-finish register. Raw vsync is active for the whole of every line whose count is strictly above vsync-begin and at most vsync-finish.
- R6: The prefetch output is high for exactly the cycle in which the block is enabled and the pixel count equals the prefetch register, on every line.
- R7: Sync-control bit 3 inverts hsync and bit 4 inverts vsync.
- R8: Sync-control bit 5 forces hsync low and bit 6 forces vsync low. Bit 1 forces both syncs and the composite sync low. A forced-low output overrides inversion.
- R9: The composite sync output equals sync-control bit 0 ANDed with (raw hsync OR raw vsync), unless bit 1 is set.
- R10: Display-control bit 1 holds display enable low while the counters keep running.
- R11: The pan register takes x from write-data bits [31:16] and y from bits [15:0], with the three low bits of x stored as zero. The pan outputs take the staged value only on the clock edge that ends the final pixel of the final line, or on any edge while enable is 0.
- R12: A write on wr_en updates its register at that clock edge. The addresses are 0 control, 1 horizontal total, 2 horizontal active, 3 hsync begin, 4 hsync finish, 5 vertical total, 6 vertical active, 7 vsync begin, 8 vsync finish, 9 prefetch position, 10 sync control, 11 display control and 12 pan. The timing registers take write-data bits [11:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| h_count | output | 12 | Current pixel count |
| v_count | output | 12 | Current line count |
| disp_en | output | 1 | Display-active window |
| hsync | output | 1 | Horizontal sync after polarity and off controls |
| vsync | output | 1 | Vertical sync after polarity and off controls |
| sync_on_rgb | output | 1 | Composite sync for the colour channel |
| prefetch | output | 1 | Early per-line fetch pulse |
| pan_x | output | 16 | Live horizontal pan offset |
| pan_y | output | 16 | Live vertical pan offset |

## Verification
Every output is a combinational function of the counter and configuration registers. A register write is therefore visible on the outputs from the clock edge that samples wr_en, and each counter step appears one edge after the state that caused it. The bench keeps its own model state that it advances on the rising edge from the same write strobes it drives. It drives inputs and compares every output on the falling edge, half a cycle after each update and half a cycle before the next. Pan updates are compared on every cycle of a frame, so a value that goes live one edge early or late is reported.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_TIM = 9;
  localparam int SYNC_W = 7;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_TIM0 = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_SYNC = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_DISP = 4'd11;
  localparam logic [ADDR_W-1:0] ADR_PAN  = 4'd12;

  // index into the timing register array (address minus ADR_TIM0)
  localparam int TI_HTOT = 0;
  localparam int TI_HACT = 1;
  localparam int TI_HSB  = 2;
  localparam int TI_HSE  = 3;
  localparam int TI_VTOT = 4;
  localparam int TI_VACT = 5;
  localparam int TI_VSB  = 6;
  localparam int TI_VSE  = 7;
  localparam int TI_PREF = 8;

  localparam int CB_EN      = 0;
  localparam int CB_REFRESH = 1;
  localparam int DB_BLANK   = 1;

  localparam int SB_SOG     = 0;
  localparam int SB_ALL_OFF = 1;
  localparam int SB_H_INV   = 3;
  localparam int SB_V_INV   = 4;
  localparam int SB_H_OFF   = 5;
  localparam int SB_V_OFF   = 6;
endpackage

// File: rtl/tgen_regs.sv
module tgen_regs
  import tgen_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int PAN_ALIGN = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DW-1:0]                wr_data,
  output logic                         en,
  output logic                         refresh,
  output logic [NUM_TIM-1:0][CW-1:0]   tim,
  output logic [SYNC_W-1:0]            sync_cfg,
  output logic                         blank,
  output logic [PW-1:0]                pan_x_stg,
  output logic [PW-1:0]                pan_y_stg
);

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      refresh   <= 1'b0;
      tim       <= '0;
      sync_cfg  <= '0;
      blank     <= 1'b0;
      pan_x_stg <= '0;
      pan_y_stg <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_CTRL) begin
        en      <= wr_data[CB_EN];
        refresh <= wr_data[CB_REFRESH];
      end
      for (int i = 0; i < NUM_TIM; i++) begin
        if (wr_addr == ADR_TIM0 + ADDR_W'(i)) tim[i] <= wr_data[CW-1:0];
      end
      if (wr_addr == ADR_SYNC) sync_cfg <= wr_data[SYNC_W-1:0];
      if (wr_addr == ADR_DISP) blank <= wr_data[DB_BLANK];
      if (wr_addr == ADR_PAN) begin
        pan_x_stg <= {wr_data[DW-1 -: PW-PAN_ALIGN], {PAN_ALIGN{1'b0}}};
        pan_y_stg <= wr_data[PW-1:0];
      end
    end
  end

endmodule

// File: rtl/tgen_counters.sv
module tgen_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] v_total,
  output logic [CW-1:0] h_cnt,
  output logic [CW-1:0] v_cnt,
  output logic          frame_end
);

  logic [CW-1:0] h_nxt, v_nxt;
  logic          line_end;

  assign line_end  = en && (h_cnt >= h_total);
  assign frame_end = line_end && (v_cnt >= v_total);

  always_comb begin
    h_nxt = h_cnt + 1'b1;
    v_nxt = v_cnt;
    if (!en) begin
      h_nxt = '0;
      v_nxt = '0;
    end else if (line_end) begin
      h_nxt = '0;
      v_nxt = (v_cnt >= v_total) ? '0 : v_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_nxt;
      v_cnt <= v_nxt;
    end
  end

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt < h_total) |=> (h_cnt == $past(h_cnt) + 1'b1)); // R2
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt >= h_total) |=> (h_cnt == '0)); // R2
  AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt >= h_total && v_cnt < v_total) |=> (v_cnt == $past(v_cnt) + 1'b1)); // R2
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (h_cnt == '0 && v_cnt == '0)); // R3

endmodule

// File: rtl/tgen_outputs.sv
module tgen_outputs
  import tgen_pkg::*;
#(
  parameter int CW = 12,
  parameter int PW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       refresh,
  input  logic                       blank,
  input  logic [NUM_TIM-1:0][CW-1:0] tim,
  input  logic [SYNC_W-1:0]          sync_cfg,
  input  logic [CW-1:0]              h_cnt,
  input  logic [CW-1:0]              v_cnt,
  input  logic                       frame_end,
  input  logic [PW-1:0]              pan_x_stg,
  input  logic [PW-1:0]              pan_y_stg,
  output logic                       disp_en,
  output logic                       hsync,
  output logic                       vsync,
  output logic                       sync_on_rgb,
  output logic                       prefetch,
  output logic [PW-1:0]              pan_x,
  output logic [PW-1:0]              pan_y
);

  logic h_raw, v_raw, all_off, pan_load;
  logic [PW-1:0] pan_x_nxt, pan_y_nxt;
  logic unused_sync;

  assign unused_sync = sync_cfg[2];
  assign all_off = sync_cfg[SB_ALL_OFF];

  assign h_raw = en && (h_cnt > tim[TI_HSB]) && (h_cnt <= tim[TI_HSE]);
  assign v_raw = en && (v_cnt > tim[TI_VSB]) && (v_cnt <= tim[TI_VSE]);

  assign hsync = (all_off || sync_cfg[SB_H_OFF]) ? 1'b0 : (h_raw ^ sync_cfg[SB_H_INV]);
  assign vsync = (all_off || sync_cfg[SB_V_OFF]) ? 1'b0 : (v_raw ^ sync_cfg[SB_V_INV]);
  assign sync_on_rgb = sync_cfg[SB_SOG] && !all_off && (h_raw || v_raw);

  assign disp_en = en && refresh && !blank &&
                   (h_cnt <= tim[TI_HACT]) && (v_cnt <= tim[TI_VACT]);
  assign prefetch = en && (h_cnt == tim[TI_PREF]);

  assign pan_load = !en || frame_end;

  always_comb begin
    pan_x_nxt = pan_x;
    pan_y_nxt = pan_y;
    if (pan_load) begin
      pan_x_nxt = pan_x_stg;
      pan_y_nxt = pan_y_stg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pan_x <= '0;
      pan_y <= '0;
    end else begin
      pan_x <= pan_x_nxt;
      pan_y <= pan_y_nxt;
    end
  end

  AST_PAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> ($stable(pan_x) && $stable(pan_y))); // R11
  AST_SYNC_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> (!hsync && !vsync && !sync_on_rgb)); // R8
  AST_PREFETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (prefetch && tim[TI_HTOT] != '0 && $stable(tim)) |=> !prefetch); // R6

endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import tgen_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32,
  parameter int PAN_ALIGN = 3,
  localparam int PW = DW / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [CW-1:0]     h_count,
  output logic [CW-1:0]     v_count,
  output logic              disp_en,
  output logic              hsync,
  output logic              vsync,
  output logic              sync_on_rgb,
  output logic              prefetch,
  output logic [PW-1:0]     pan_x,
  output logic [PW-1:0]     pan_y
);

  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic                       en, refresh, blank, frame_end;
  logic [NUM_TIM-1:0][CW-1:0] tim;
  logic [SYNC_W-1:0]          sync_cfg;
  logic [PW-1:0]              pan_x_stg, pan_y_stg;

  tgen_regs #(.CW(CW), .DW(DW), .PW(PW), .PAN_ALIGN(PAN_ALIGN)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en(en), .refresh(refresh), .tim(tim), .sync_cfg(sync_cfg), .blank(blank),
    .pan_x_stg(pan_x_stg), .pan_y_stg(pan_y_stg)
  );

  tgen_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .en(en),
    .h_total(tim[TI_HTOT]), .v_total(tim[TI_VTOT]),
    .h_cnt(h_count), .v_cnt(v_count), .frame_end(frame_end)
  );

  tgen_outputs #(.CW(CW), .PW(PW)) u_out (
    .clk(clk), .rst_n(rst_q_n), .en(en), .refresh(refresh), .blank(blank),
    .tim(tim), .sync_cfg(sync_cfg), .h_cnt(h_count), .v_cnt(v_count),
    .frame_end(frame_end), .pan_x_stg(pan_x_stg), .pan_y_stg(pan_y_stg),
    .disp_en(disp_en), .hsync(hsync), .vsync(vsync), .sync_on_rgb(sync_on_rgb),
    .prefetch(prefetch), .pan_x(pan_x), .pan_y(pan_y)
  );

endmodule

// File: tb/disp_tgen_tb.sv
`timescale 1ns/1ps
module disp_tgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] h_count, v_count;
  logic        disp_en, hsync, vsync, sync_on_rgb, prefetch;
  logic [15:0] pan_x, pan_y;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  disp_tgen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_count(h_count), .v_count(v_count), .disp_en(disp_en), .hsync(hsync),
    .vsync(vsync), .sync_on_rgb(sync_on_rgb), .prefetch(prefetch),
    .pan_x(pan_x), .pan_y(pan_y)
  );

  // independent model built from the requirements
  logic        m_en, m_ref, m_blank;
  logic [11:0] m_tim [9];
  logic [6:0]  m_sync;
  logic [15:0] m_sx, m_sy, m_px, m_py;
  logic [11:0] m_h, m_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_ref <= 0; m_blank <= 0; m_sync <= 0;
      for (int i = 0; i < 9; i++) m_tim[i] <= 0;
      m_sx <= 0; m_sy <= 0; m_px <= 0; m_py <= 0; m_h <= 0; m_v <= 0;
    end else begin
      if (!m_en) begin
        m_h <= 0; m_v <= 0;
      end else if (m_h >= m_tim[0]) begin
        m_h <= 0;
        m_v <= (m_v >= m_tim[4]) ? 12'd0 : m_v + 12'd1;
      end else m_h <= m_h + 12'd1;
      if (!m_en || (m_h >= m_tim[0] && m_v >= m_tim[4])) begin
        m_px <= m_sx; m_py <= m_sy;
      end
      if (wr_en) begin
        case (wr_addr)
          4'd0:  begin m_en <= wr_data[0]; m_ref <= wr_data[1]; end
          4'd10: m_sync <= wr_data[6:0];
          4'd11: m_blank <= wr_data[1];
          4'd12: begin m_sx <= {wr_data[31:19], 3'b000}; m_sy <= wr_data[15:0]; end
          default: if (wr_addr >= 4'd1 && wr_addr <= 4'd9) m_tim[wr_addr - 4'd1] <= wr_data[11:0];
        endcase
      end
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic check_cycle(input string lc, input string ld, input string ls);
    logic hr, vr, ehs, evs, esog, ede;
    hr = m_en && m_h > m_tim[2] && m_h <= m_tim[3];
    vr = m_en && m_v > m_tim[6] && m_v <= m_tim[7];
    ehs = (m_sync[1] || m_sync[5]) ? 1'b0 : hr ^ m_sync[3];
    evs = (m_sync[1] || m_sync[6]) ? 1'b0 : vr ^ m_sync[4];
    esog = m_sync[0] && !m_sync[1] && (hr || vr);
    ede = m_en && m_ref && !m_blank && m_h <= m_tim[1] && m_v <= m_tim[5];
    chk(lc, "h_count", int'(h_count), int'(m_h));
    chk(lc, "v_count", int'(v_count), int'(m_v));
    chk(ld, "disp_en", int'(disp_en), int'(ede));
    chk(ls, "hsync", int'(hsync), int'(ehs));
    chk(ls, "vsync", int'(vsync), int'(evs));
    chk("R9", "sync_on_rgb", int'(sync_on_rgb), int'(esog));
    chk("R6", "prefetch", int'(prefetch), int'(m_en && m_h == m_tim[8]));
    chk("R11", "pan_x", int'(pan_x), int'(m_px));
    chk("R11", "pan_y", int'(pan_y), int'(m_py));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input string lc, input string ld, input string ls);
    for (int i = 0; i < n; i++) begin
      check_cycle(lc, ld, ls);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "h_count", int'(h_count), 0);
    chk("R1", "v_count", int'(v_count), 0);
    chk("R1", "disp_en", int'(disp_en), 0);
    chk("R1", "hsync", int'(hsync), 0);
    chk("R1", "vsync", int'(vsync), 0);
    chk("R1", "sync_on_rgb", int'(sync_on_rgb), 0);
    chk("R1", "prefetch", int'(prefetch), 0);
    chk("R1", "pan", int'({pan_x, pan_y}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_basic;
    // R12: 10 pixels x 6 lines, 6x3 active, syncs after pixel 6 and line 3
    wr(4'd1, 32'd9); wr(4'd2, 32'd5); wr(4'd3, 32'd6); wr(4'd4, 32'd7);
    wr(4'd5, 32'd5); wr(4'd6, 32'd2); wr(4'd7, 32'd3); wr(4'd8, 32'd4);
    wr(4'd9, 32'd7);
    wr(4'd0, 32'h3);
    chk("R2", "h_count after enable", int'(h_count), 0);
    run(130, "R2", "R4", "R5");
  endtask

  task automatic t_pan;
    wr(4'd12, {16'h0013, 16'h0021});
    chk("R11", "pan_x held mid-frame", int'(pan_x), 0);
    run(70, "R2", "R4", "R5");
    chk("R11", "pan_x aligned", int'(pan_x), 16);
    chk("R11", "pan_y", int'(pan_y), 33);
  endtask

  task automatic t_polarity;
    wr(4'd10, 32'h18); run(60, "R2", "R4", "R7");
    wr(4'd10, 32'h38); run(60, "R2", "R4", "R8");
    wr(4'd10, 32'h59); run(60, "R2", "R4", "R8");
    wr(4'd10, 32'h1B); run(60, "R2", "R4", "R8");
    wr(4'd10, 32'h01); run(60, "R2", "R4", "R9");
    wr(4'd10, 32'h00);
  endtask

  task automatic t_blank;
    wr(4'd11, 32'h2); run(60, "R2", "R10", "R5");
    wr(4'd11, 32'h0);
    wr(4'd0, 32'h1); run(60, "R2", "R4", "R5");
    wr(4'd0, 32'h3); run(10, "R2", "R4", "R5");
  endtask

  task automatic t_disable;
    wr(4'd10, 32'h18);
    wr(4'd0, 32'h0);
    wr(4'd12, {16'h00F8, 16'h0007});
    run(8, "R3", "R4", "R3");
    chk("R3", "h_count held", int'(h_count), 0);
    chk("R3", "pan_x passes while disabled", int'(pan_x), 248);
    wr(4'd0, 32'h3);
    run(30, "R2", "R4", "R7");
  endtask

  initial begin
    t_reset;
    t_basic;
    t_pan;
    t_polarity;
    t_blank;
    t_disable;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule